// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This unit sits beside a cluster of harts and gives each one two interrupt sources: a machine software-interrupt flag that any bus master can raise or clear, and a timer interrupt produced by comparing a per-hart 64-bit compare value against one shared 64-bit time counter. The time counter advances by one on every cycle in which the tick-enable input is high. Software uses the counter to read wall time and the compare registers to schedule the next timer interrupt.

All access goes through a small register bus. One request takes one cycle and carries an address, a write enable and 32 bits of write data. Read data appears one cycle later. The address space is split into three windows, each placed by its own base parameter: software-interrupt words, compare registers, and the time counter. Every register is 32 bits wide. The 64-bit quantities are therefore reached as a low word and a high word, and a write to one half never disturbs the other half.

Each timer interrupt is a level. It follows `compare <= time` as an unsigned 64-bit comparison, registered once. Writing a compare value that already lies in the past raises the line on the next cycle. Writing a future value lowers it.

Top module: `hart_timer_swi`

## Requirements
- R1: A write to the software-interrupt word of hart h sets `swi_o[h]` after the clock edge that takes the request when the write data is nonzero (any bit set), and clears it when the write data is zero.
- R2: The software-interrupt word of hart h sits at `SWI_BASE + 4*h`. A read there returns the pending flag in bit 0, with bits 31:1 zero.
- R3: The compare register of hart h occupies `CMP_BASE + 8*h` (bits 31:0) and `CMP_BASE + 8*h + 4` (bits 63:32), and both words read back what was written.
- R4: A write to one compare half replaces only those 32 bits and keeps the other half unchanged.
- R5: `tmr_o[h]` is high exactly when the hart's compare value is unsigned less than or equal to the time counter, delayed by one register. A compare value written in the past raises the line one cycle after it is stored.
- R6: A timer line that is high stays high while its compare register is not written, and goes low once a compare value greater than the time counter is written.
- R7: The time counter increments by one at every clock edge where `tick_en` is high and holds otherwise. Its low word reads at `TIME_BASE` and its high word at `TIME_BASE + 4`.
- R8: Writes to either time-counter word are ignored.
- R9: Reads of any address outside the valid words listed in R2, R3 and R7, including misaligned offsets inside a window, return zero. Writes to such addresses change no state.
- R10: After reset the software-interrupt flags, the compare registers and the time counter are zero. All timer lines are therefore high from the second cycle after reset (0 <= 0).
- R11: Read data is registered. It shows the addressed register as it was in the request cycle, on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time counter advance enable |
| req_valid | input | 1 | Bus request this cycle |
| req_we | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| swi_o | output | NUM_HARTS | Software-interrupt line per hart |
| tmr_o | output | NUM_HARTS | Timer-interrupt line per hart |

## Verification
A wrong decode shows up at once in the registered read data or in the wrong hart's interrupt line. For this reason the bench sweeps every byte address of a small configuration: first with writes to all invalid addresses, then with reads of all addresses checked against an arithmetic model. A corrupted compare half or a stuck counter bit becomes visible at the timer line within two cycles. The bench walks compare values from three below to three above the current time, so an off-by-one error in the unsigned comparison or a missing delay register also shows within two cycles. Software-interrupt flags are visible directly on the port in the cycle after the write.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_SWI,
    RG_CMP_LO,
    RG_CMP_HI,
    RG_TIME_LO,
    RG_TIME_HI
  } region_e;
endpackage

// File: rtl/ctu_decode.sv
module ctu_decode
  import ctu_pkg::*;
#(
  parameter int                NUM_HARTS = 2,
  parameter int                ADDR_W    = 12,
  parameter int                IDX_W     = 1,
  parameter logic [ADDR_W-1:0] SWI_BASE  = '0,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  hart_idx
);
  localparam logic [ADDR_W:0]   SWI_SPAN  = (ADDR_W+1)'(4 * NUM_HARTS);
  localparam logic [ADDR_W:0]   CMP_SPAN  = (ADDR_W+1)'(8 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] TIME_HI_A = TIME_BASE + ADDR_W'(4);

  logic [ADDR_W:0] addr_x, swi_off, cmp_off;
  logic            in_swi, in_cmp;

  assign addr_x  = {1'b0, addr};
  assign swi_off = addr_x - {1'b0, SWI_BASE};
  assign cmp_off = addr_x - {1'b0, CMP_BASE};
  assign in_swi  = (addr_x >= {1'b0, SWI_BASE}) && (swi_off < SWI_SPAN);
  assign in_cmp  = (addr_x >= {1'b0, CMP_BASE}) && (cmp_off < CMP_SPAN);

  always_comb begin
    region   = RG_NONE;
    hart_idx = '0;
    if (in_swi) begin
      hart_idx = swi_off[IDX_W+1:2];
      if (addr[1:0] == 2'b00) region = RG_SWI;
    end else if (in_cmp) begin
      hart_idx = cmp_off[IDX_W+2:3];
      if (addr[2:0] == 3'd0)      region = RG_CMP_LO;
      else if (addr[2:0] == 3'd4) region = RG_CMP_HI;
    end else if (addr == TIME_BASE) begin
      region = RG_TIME_LO;
    end else if (addr == TIME_HI_A) begin
      region = RG_TIME_HI;
    end
  end
endmodule

// File: rtl/ctu_timebase.sv
module ctu_timebase #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (tick_en) count <= count + CNT_W'(1);
  end

  a_r7_advance: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> count == $past(count) + CNT_W'(1));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count));
endmodule

// File: rtl/ctu_hart.sv
module ctu_hart #(
  parameter int CNT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  time_now,
  input  logic              swi_we,
  input  logic              cmp_lo_we,
  input  logic              cmp_hi_we,
  input  logic [WORD_W-1:0] wdata,
  output logic              swi,
  output logic [CNT_W-1:0]  cmp,
  output logic              tmr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      swi <= 1'b0;
      cmp <= '0;
      tmr <= 1'b0;
    end else begin
      if (swi_we)    swi <= |wdata;
      if (cmp_lo_we) cmp[WORD_W-1:0] <= wdata;
      if (cmp_hi_we) cmp[CNT_W-1:WORD_W] <= wdata;
      tmr <= (cmp <= time_now);
    end
  end

  a_r1_set: assert property (@(posedge clk) disable iff (rst)
    (swi_we && wdata != '0) |=> swi);
  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    (swi_we && wdata == '0) |=> !swi);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !swi_we |=> $stable(swi));
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (cmp_lo_we && !cmp_hi_we) |=> cmp[CNT_W-1:WORD_W] == $past(cmp[CNT_W-1:WORD_W]));
  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (cmp_hi_we && !cmp_lo_we) |=> cmp[WORD_W-1:0] == $past(cmp[WORD_W-1:0]));
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (tmr && !cmp_lo_we && !cmp_hi_we && !$past(cmp_lo_we) && !$past(cmp_hi_we)) |=> tmr);
endmodule

// File: rtl/hart_timer_swi.sv
module hart_timer_swi
  import ctu_pkg::*;
#(
  parameter int                NUM_HARTS = 2,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] SWI_BASE  = 12'h000,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 12'h400,
  parameter logic [ADDR_W-1:0] TIME_BASE = 12'hFF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] swi_o,
  output logic [NUM_HARTS-1:0] tmr_o
);
  localparam int CNT_W  = 64;
  localparam int WORD_W = 32;
  localparam int IDX_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  region_e           region;
  logic [IDX_W-1:0]  hart_idx;
  logic [CNT_W-1:0]  time_now;
  logic [CNT_W-1:0]  cmp_all [NUM_HARTS];
  logic              wr_go;
  logic [WORD_W-1:0] rd_mux;

  ctu_decode #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .SWI_BASE(SWI_BASE), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_decode (
    .addr(req_addr), .region(region), .hart_idx(hart_idx)
  );

  ctu_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk(clk), .rst(rst), .tick_en(tick_en), .count(time_now)
  );

  assign wr_go = req_valid && req_we;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic hit;
    assign hit = (hart_idx == IDX_W'(h));
    ctu_hart #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_hart (
      .clk(clk), .rst(rst), .time_now(time_now),
      .swi_we   (wr_go && hit && region == RG_SWI),
      .cmp_lo_we(wr_go && hit && region == RG_CMP_LO),
      .cmp_hi_we(wr_go && hit && region == RG_CMP_HI),
      .wdata(req_wdata),
      .swi(swi_o[h]), .cmp(cmp_all[h]), .tmr(tmr_o[h])
    );
  end

  always_comb begin
    rd_mux = '0;
    unique case (region)
      RG_SWI:     rd_mux = {{(WORD_W-1){1'b0}}, swi_o[hart_idx]};
      RG_CMP_LO:  rd_mux = cmp_all[hart_idx][WORD_W-1:0];
      RG_CMP_HI:  rd_mux = cmp_all[hart_idx][CNT_W-1:WORD_W];
      RG_TIME_LO: rd_mux = time_now[WORD_W-1:0];
      RG_TIME_HI: rd_mux = time_now[CNT_W-1:WORD_W];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                          rsp_rdata <= '0;
    else if (req_valid && !req_we)    rsp_rdata <= rd_mux;
  end

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && region == RG_NONE) |=> rsp_rdata == '0);
  a_r2_swi_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && region == RG_SWI) |=> rsp_rdata[WORD_W-1:1] == '0);
  a_r11_time_lo: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we && region == RG_TIME_LO) |=> rsp_rdata == $past(time_now[WORD_W-1:0]));
endmodule

// File: tb/test_hart_timer_swi.sv
module test_hart_timer_swi;
  localparam int          CLK_PERIOD = 10;
  localparam int          NUM_HARTS  = 2;
  localparam int          ADDR_W     = 12;
  localparam int          SWI_B      = 'h000;
  localparam int          CMP_B      = 'h400;
  localparam int          TIME_B     = 'hFF8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 tick_en = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_we = 1'b0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [31:0]          req_wdata = '0;
  logic [31:0]          rsp_rdata;
  logic [NUM_HARTS-1:0] swi_o;
  logic [NUM_HARTS-1:0] tmr_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic        swi_m [NUM_HARTS];
  logic [63:0] cmp_m [NUM_HARTS];
  logic [63:0] time_m;

  hart_timer_swi #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W),
    .SWI_BASE(ADDR_W'(SWI_B)), .CMP_BASE(ADDR_W'(CMP_B)), .TIME_BASE(ADDR_W'(TIME_B))
  ) i_hart_timer_swi (
    .clk(clk), .rst(rst), .tick_en(tick_en), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .swi_o(swi_o), .tmr_o(tmr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_swi(input int a);
    return a >= SWI_B && a < SWI_B + 4*NUM_HARTS;
  endfunction
  function automatic bit in_cmp(input int a);
    return a >= CMP_B && a < CMP_B + 8*NUM_HARTS;
  endfunction
  function automatic bit valid_addr(input int a);
    if (in_swi(a)) return ((a - SWI_B) % 4) == 0;
    if (in_cmp(a)) return ((a - CMP_B) % 8) == 0 || ((a - CMP_B) % 8) == 4;
    return a == TIME_B || a == TIME_B + 4;
  endfunction
  function automatic string tag_of(input int a);
    if (!valid_addr(a)) return "R9";
    if (in_swi(a))      return "R2";
    if (in_cmp(a))      return "R3";
    return "R7";
  endfunction
  function automatic logic [31:0] exp_read(input int a);
    if (!valid_addr(a)) return 32'h0;
    if (in_swi(a)) return {31'h0, swi_m[(a - SWI_B) / 4]};
    if (in_cmp(a)) begin
      if (((a - CMP_B) % 8) == 0) return cmp_m[(a - CMP_B) / 8][31:0];
      return cmp_m[(a - CMP_B) / 8][63:32];
    end
    if (a == TIME_B) return time_m[31:0];
    return time_m[63:32];
  endfunction

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    if (valid_addr(a)) begin
      if (in_swi(a)) swi_m[(a - SWI_B) / 4] = (d != 0);
      else if (in_cmp(a)) begin
        if (((a - CMP_B) % 8) == 0) cmp_m[(a - CMP_B) / 8][31:0] = d;
        else                         cmp_m[(a - CMP_B) / 8][63:32] = d;
      end
    end
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = ADDR_W'(a);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (k) @(negedge clk);
    tick_en = 1'b0;
    time_m = time_m + 64'(k);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic check_lines(input string req);
    for (int h = 0; h < NUM_HARTS; h++) begin
      check(req, {63'h0, tmr_o[h]}, {63'h0, (cmp_m[h] <= time_m)});
      check(req, {63'h0, swi_o[h]}, {63'h0, swi_m[h]});
    end
  endtask

  task automatic set_cmp(input int h, input logic [63:0] v);
    bus_write(CMP_B + 8*h, v[31:0]);
    bus_write(CMP_B + 8*h + 4, v[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int h = 0; h < NUM_HARTS; h++) begin swi_m[h] = 1'b0; cmp_m[h] = '0; end
    time_m = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R10: reset state, all timers fire on 0 <= 0
    check_lines("R10");
    check("R10", {63'h0, ^tmr_o}, {63'h0, ^{NUM_HARTS{1'b1}}});
    bus_read(TIME_B, rd);
    check("R10", {32'h0, rd}, 64'h0);

    // R5: future compare keeps line low, reaching it raises the line
    set_cmp(0, 64'h10);
    set_cmp(1, 64'h1_0000_0000);
    settle();
    check_lines("R5");
    ticks(15);
    settle();
    check_lines("R5");
    check("R5", {63'h0, tmr_o[0]}, 64'h0);
    ticks(1);
    settle();
    check("R5", {63'h0, tmr_o[0]}, 64'h1);
    check_lines("R5");

    // R11: registered read of time
    bus_read(TIME_B, rd);
    check("R11", {32'h0, rd}, 64'd16);
    bus_read(TIME_B + 4, rd);
    check("R7", {32'h0, rd}, 64'h0);

    // R6 and R4: hi write pushes compare to future, lo preserved
    bus_write(CMP_B + 4, 32'h1);
    settle();
    check("R6", {63'h0, tmr_o[0]}, 64'h0);
    bus_read(CMP_B, rd);
    check("R4", {32'h0, rd}, 64'h10);
    bus_write(CMP_B, 32'h5);
    bus_read(CMP_B + 4, rd);
    check("R4", {32'h0, rd}, 64'h1);
    settle();
    check("R6", {63'h0, tmr_o[0]}, 64'h0);
    bus_write(CMP_B + 4, 32'h0);
    settle();
    check("R5", {63'h0, tmr_o[0]}, 64'h1);

    // R6 sticky while time advances
    ticks(7);
    settle();
    check("R6", {63'h0, tmr_o[0]}, 64'h1);

    // R5/R6 sweep around current time
    for (int d = -3; d <= 3; d++) begin
      set_cmp(0, time_m + 64'(d));
      set_cmp(1, time_m - 64'(d));
      settle();
      check_lines("R5");
      check("R6", {63'h0, tmr_o[0]}, {63'h0, (d <= 0)});
    end

    // R1: software-interrupt set/clear
    bus_write(SWI_B + 4, 32'hA5);
    check("R1", {63'h0, swi_o[1]}, 64'h1);
    check("R1", {63'h0, swi_o[0]}, 64'h0);
    bus_read(SWI_B + 4, rd);
    check("R2", {32'h0, rd}, 64'h1);
    bus_write(SWI_B + 4, 32'h0);
    check("R1", {63'h0, swi_o[1]}, 64'h0);
    bus_write(SWI_B, 32'h8000_0000);
    check("R1", {63'h0, swi_o[0]}, 64'h1);
    bus_write(SWI_B, 32'h0);
    check("R1", {63'h0, swi_o[0]}, 64'h0);

    // R8: time writes ignored
    bus_write(TIME_B, 32'hFFFF_FFFF);
    bus_write(TIME_B + 4, 32'hFFFF_FFFF);
    bus_read(TIME_B, rd);
    check("R8", {32'h0, rd}, {32'h0, time_m[31:0]});
    bus_read(TIME_B + 4, rd);
    check("R8", {32'h0, rd}, {32'h0, time_m[63:32]});

    // R9: writes to every invalid address change nothing
    set_cmp(0, 64'h1234_5678_9ABC_DEF0);
    set_cmp(1, 64'h0FED_CBA9_8765_4321);
    bus_write(SWI_B + 4, 32'h1);
    for (int a = 0; a < (1 << ADDR_W); a++)
      if (!valid_addr(a)) bus_write(a, 32'hFFFF_FFFF);
    settle();
    check_lines("R9");

    // full read sweep against model
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      bus_read(a, rd);
      check(tag_of(a), {32'h0, rd}, {32'h0, exp_read(a)});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule